// File: doc/BRIEF.md
# Fractional Clock Rate Scaler

This block turns a free-running clock into an average slower rate without a PLL. It produces a clock-enable pulse train that passes a chosen share of the input cycles. The share is set through a 32-bit control register on a simple write port with combinational read-back. A 3-bit scale field inside that register selects how many of every 8 input cycles are kept. Logic in a downstream domain qualifies its flops with the enable and so runs at the scaled rate.

Time is split into fixed windows of 8 input cycles. A small two-state sequencer tracks the position within the window. `PH_BODY` covers slots 0 to 6 and moves to `PH_EDGE` when the slot counter reaches 6. `PH_EDGE` is slot 7, the last slot, and always returns to `PH_BODY`. In `PH_EDGE` the scale field is sampled into the active keep count for the next window. Within a window, an accumulator adds the keep count on every cycle. The enable is raised on each cycle where the running sum reaches 8, which spreads the kept cycles evenly across the window.

A build-time parameter picks the field encoding. In the default inverted encoding, field value k keeps 8 − k cycles, so zero means full rate. In the direct encoding, field value k keeps k + 1 cycles.

Top module: `frac_rate_scaler`

## Requirements
- R1: After reset the control register reads 0x00000000, the window restarts at slot 0, and the ratio for field value 0 applies from the first window: 8 of 8 cycles kept in inverted mode, 1 of 8 in direct mode.
- R2: With the inverted encoding (INVERTED=1), field value k in bits 10:8 yields exactly 8 − k enable cycles in every 8-cycle window.
- R3: With the direct encoding (INVERTED=0), field value k in bits 10:8 yields exactly k + 1 enable cycles in every 8-cycle window.
- R4: A write changes only bits 10:8 of the control register; every other bit keeps its previous value (zero from reset), whatever the write data holds there.
- R5: `reg_rdata` shows the register contents; a value written on a rising edge with `reg_wr` high is readable in the following cycle, and without `reg_wr` the read value does not change.
- R6: A new field value takes effect only at the start of the window after the one in which it was written; a window in progress completes with the ratio it started with.
- R7: Kept cycles are spread over the window: with a keep count of 4 or fewer, no two enables fall on adjacent cycles within a window; with 5 or more, at least one adjacent pair exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock whose cycles are passed or dropped |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data; only the scale field bits are taken |
| reg_rdata | output | 32 | Current control register contents |
| clk_en | output | 1 | One-cycle enable, high on each kept input cycle |

## Verification
The read-back value is due one cycle after the write edge, so the bench drives a write on a falling edge and compares `reg_rdata` at the next falling edge. The enable is a function of registered state, so the bench samples it on falling edges. Each sample is tied to a cycle index counted from the release of reset, and windows are formed as index divided by 8. A write whose edge moves the index to p first governs window floor(p/8) + 1. The driver therefore queues the old ratio for window floor(p/8) and the new ratio for the next three windows. The monitor compares each queued window only after its slot 7 sample.

// File: rtl/frs_pkg.sv
package frs_pkg;

    // Position of the window sequencer inside an 8-slot window
    typedef enum logic {
        PH_BODY = 1'b0,   // slots 0 .. DENOM-2
        PH_EDGE = 1'b1    // last slot: next ratio is latched here
    } frs_phase_e;

endpackage

// File: rtl/frs_ctrl_reg.sv
module frs_ctrl_reg #(
    parameter int REG_W     = 32,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic [FIELD_W-1:0] field
);

    localparam logic [REG_W-1:0] FMASK = REG_W'(((1 << FIELD_W) - 1) << FIELD_LSB);

    logic [REG_W-1:0] ctrl_q;

    // Masked update: bits outside the scale field are never written
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q <= (ctrl_q & ~FMASK) | (wdata & FMASK);
        end
    end

    assign rdata = ctrl_q;
    assign field = ctrl_q[FIELD_LSB +: FIELD_W];

endmodule

// File: rtl/frs_window_fsm.sv
module frs_window_fsm
    import frs_pkg::*;
#(
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [FIELD_W-1:0] win_cnt,
    output logic               load_window,
    output frs_phase_e         phase
);

    localparam int DENOM = 1 << FIELD_W;
    localparam logic [FIELD_W-1:0] LAST_BODY = FIELD_W'(DENOM - 2);

    frs_phase_e phase_q, phase_d;
    logic [FIELD_W-1:0] cnt_q;

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_BODY: if (cnt_q == LAST_BODY) phase_d = PH_EDGE;
            PH_EDGE: phase_d = PH_BODY;
            default: phase_d = PH_BODY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_BODY;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Slot counter wraps naturally at DENOM
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + FIELD_W'(1);
        end
    end

    // Outputs
    always_comb begin
        load_window = 1'b0;
        unique case (phase_q)
            PH_BODY: load_window = 1'b0;
            PH_EDGE: load_window = 1'b1;
            default: load_window = 1'b0;
        endcase
    end

    assign win_cnt = cnt_q;
    assign phase   = phase_q;

endmodule

// File: rtl/frs_spreader.sv
module frs_spreader #(
    parameter int FIELD_W  = 3,
    parameter int INVERTED = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_window,
    input  logic [FIELD_W-1:0] field,
    output logic [FIELD_W:0]   active_keep,
    output logic               clk_en
);

    localparam int KW    = FIELD_W + 1;
    localparam int DENOM = 1 << FIELD_W;
    localparam logic [KW-1:0] DEN_K      = KW'(DENOM);
    localparam logic [KW-1:0] RESET_KEEP = (INVERTED != 0) ? DEN_K : KW'(1);

    logic [KW-1:0] keep_next;
    logic [KW-1:0] keep_q;
    logic [KW-1:0] acc_q;
    logic [KW:0]   sum;
    logic          hit;

    // Field encoding chosen at build time
    generate
        if (INVERTED != 0) begin : g_inverted
            assign keep_next = DEN_K - {1'b0, field};
        end else begin : g_direct
            assign keep_next = {1'b0, field} + KW'(1);
        end
    endgenerate

    assign sum = {1'b0, acc_q} + {1'b0, keep_q};
    assign hit = (sum >= {1'b0, DEN_K});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_q <= RESET_KEEP;
            acc_q  <= '0;
        end else if (load_window) begin
            keep_q <= keep_next;
            acc_q  <= '0;
        end else if (hit) begin
            acc_q  <= KW'(sum - {1'b0, DEN_K});
        end else begin
            acc_q  <= sum[KW-1:0];
        end
    end

    assign active_keep = keep_q;
    assign clk_en      = hit;

endmodule

// File: rtl/frac_rate_scaler.sv
module frac_rate_scaler
    import frs_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 3,
    parameter int INVERTED  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             clk_en
);

    logic [FIELD_W-1:0] scale_field;
    logic [FIELD_W-1:0] win_cnt;
    logic               load_window;
    logic [FIELD_W:0]   active_keep;
    frs_phase_e         phase;

    frs_ctrl_reg #(
        .REG_W    (REG_W),
        .FIELD_LSB(FIELD_LSB),
        .FIELD_W  (FIELD_W)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (reg_wr),
        .wdata(reg_wdata),
        .rdata(reg_rdata),
        .field(scale_field)
    );

    frs_window_fsm #(
        .FIELD_W(FIELD_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_cnt    (win_cnt),
        .load_window(load_window),
        .phase      (phase)
    );

    frs_spreader #(
        .FIELD_W (FIELD_W),
        .INVERTED(INVERTED)
    ) u_spread (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_window(load_window),
        .field      (scale_field),
        .active_keep(active_keep),
        .clk_en     (clk_en)
    );

endmodule

// File: rtl/frs_checker.sv
module frs_checker
    import frs_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [REG_W-1:0]   reg_rdata,
    input logic               clk_en,
    input logic [FIELD_W:0]   active_keep,
    input logic [FIELD_W-1:0] win_cnt,
    input logic               load_window,
    input frs_phase_e         phase
);

    localparam int DENOM = 1 << FIELD_W;
    localparam logic [REG_W-1:0] FMASK = REG_W'(((1 << FIELD_W) - 1) << FIELD_LSB);
    localparam logic [FIELD_W:0] DEN_K  = (FIELD_W + 1)'(DENOM);
    localparam logic [FIELD_W:0] HALF_K = (FIELD_W + 1)'(DENOM / 2);
    localparam logic [FIELD_W-1:0] LAST_SLOT = FIELD_W'(DENOM - 1);

    // R4: bits outside the scale field never become set
    a_r4_outside_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~FMASK) == '0);

    // R5: without a write strobe the register holds its value
    a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_rdata));

    // R6: the ratio changes only across a window edge
    a_r6_ratio_only_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !load_window |=> $stable(active_keep));

    // R6: the window edge coincides with the last slot
    a_r6_edge_on_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EDGE) == (win_cnt == LAST_SLOT));

    // R2: keep count stays within 1 .. DENOM
    a_r2_keep_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active_keep != '0 && active_keep <= DEN_K);

    // R2: a full keep count passes every cycle
    a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        active_keep == DEN_K |-> clk_en);

    // R7: at half rate or below, an enable is never followed by another in the same window
    a_r7_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && active_keep <= HALF_K && !load_window) |=> !clk_en);

endmodule

bind frac_rate_scaler frs_checker #(
    .REG_W    (REG_W),
    .FIELD_LSB(FIELD_LSB),
    .FIELD_W  (FIELD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .clk_en     (clk_en),
    .active_keep(active_keep),
    .win_cnt    (win_cnt),
    .load_window(load_window),
    .phase      (phase)
);

// File: tb/frac_rate_scaler_bench.sv
`timescale 1ns/1ps
module frac_rate_scaler_bench;

    localparam int SLOTS = 8;
    localparam int NWIN  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rd_inv, rd_dir;
    logic        en_inv, en_dir;

    always #2 clk = ~clk;   // 250 MHz

    frac_rate_scaler #(.INVERTED(1)) u_frac_rate_scaler (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_inv), .clk_en(en_inv));

    frac_rate_scaler #(.INVERTED(0)) u_frac_rate_scaler_direct (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_dir), .clk_en(en_dir));

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int win;
        int keep_inv;
        int keep_dir;
        bit carried;   // window still running on the old ratio
    } item_t;
    item_t sbq[$];

    int cur_inv = 8;
    int cur_dir = 1;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: count enables per window and compare with queued expectations
    int  cnt_inv = 0, cnt_dir = 0;
    bit  adj_inv = 0, adj_dir = 0;
    bit  prev_inv = 0, prev_dir = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            int slot;
            int win;
            slot = cyc % SLOTS;
            win  = cyc / SLOTS;
            if (slot == 0) begin
                cnt_inv = 0; cnt_dir = 0; adj_inv = 0; adj_dir = 0;
            end
            if (slot != 0 && en_inv && prev_inv) adj_inv = 1;
            if (slot != 0 && en_dir && prev_dir) adj_dir = 1;
            cnt_inv += int'(en_inv);
            cnt_dir += int'(en_dir);
            prev_inv = en_inv;
            prev_dir = en_dir;
            if (slot == SLOTS - 1 && win >= 1) begin
                while (sbq.size() > 0 && sbq[0].win < win) begin
                    check(1'b0, "R6", "window item missed", sbq[0].win, win);
                    void'(sbq.pop_front());
                end
                if (sbq.size() > 0 && sbq[0].win == win) begin
                    item_t it;
                    it = sbq.pop_front();
                    if (it.carried) begin
                        check(cnt_inv == it.keep_inv, "R6", "inverted count in window of write", cnt_inv, it.keep_inv);
                        check(cnt_dir == it.keep_dir, "R6", "direct count in window of write", cnt_dir, it.keep_dir);
                    end else begin
                        check(cnt_inv == it.keep_inv, "R2", "inverted keep count", cnt_inv, it.keep_inv);
                        check(cnt_dir == it.keep_dir, "R3", "direct keep count", cnt_dir, it.keep_dir);
                    end
                    check(adj_inv == (it.keep_inv > 4), "R7", "inverted adjacency", int'(adj_inv), int'(it.keep_inv > 4));
                    check(adj_dir == (it.keep_dir > 4), "R7", "direct adjacency", int'(adj_dir), int'(it.keep_dir > 4));
                end
            end
        end
    end

    // Driver: write one value and queue the windows it governs
    task automatic write_field(input int k, input logic [31:0] junk);
        logic [31:0] data;
        int p, w;
        data = (junk & ~32'h0000_0700) | (32'(k) << 8);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = ~data;
        p = cyc;
        w = p / SLOTS + 1;
        check(rd_inv == (32'(k) << 8), "R4", "read-back masks other bits", int'(rd_inv), k << 8);
        check(rd_dir == (32'(k) << 8), "R5", "read-back after write", int'(rd_dir), k << 8);
        if (w - 1 >= 1) sbq.push_back('{w - 1, cur_inv, cur_dir, 1'b1});
        cur_inv = 8 - k;
        cur_dir = k + 1;
        for (int i = 0; i < NWIN; i++) sbq.push_back('{w + i, cur_inv, cur_dir, 1'b0});
        while (cyc < (w + NWIN) * SLOTS) @(negedge clk);
        check(rd_inv == (32'(k) << 8), "R5", "value held without write", int'(rd_inv), k << 8);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(rd_inv == 32'h0, "R1", "reset read-back inverted", int'(rd_inv), 0);
        check(rd_dir == 32'h0, "R1", "reset read-back direct", int'(rd_dir), 0);
        #1 rst_n = 1'b1;
        // R1: field 0 ratio from the first complete window
        sbq.push_back('{1, 8, 1, 1'b0});
        sbq.push_back('{2, 8, 1, 1'b0});
        while (cyc < 3 * SLOTS) @(negedge clk);
        write_field(3, 32'hFFFF_FFFF);
        write_field(7, 32'hA5A5_5A5A);
        write_field(1, 32'h0F0F_F0F0);
        write_field(5, 32'h1234_5678);
        write_field(0, 32'hFFFF_F8FF);
        write_field(6, 32'h8000_0001);
        write_field(2, 32'h0000_0000);
        write_field(4, 32'hDEAD_BEEF);
        repeat (2) @(negedge clk);
        check(sbq.size() == 0, "R6", "queue drained", sbq.size(), 0);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        report();
    end

endmodule